// File: doc/BRIEF.md
# Bus-Mapped Pulse-Width Modulator

This block generates a single pulse-width modulated output from a configuration held in one 32-bit word on a simple memory-mapped slave port. The low half of the word is the waveform period in clock cycles. The high half is the number of cycles the output stays high at the start of each period. A single bus write replaces both values together. A bus read returns the stored word one clock later.

A free-running phase counter steps through each period. A new word does not disturb a period that is already running. It is adopted at the next period wrap, so the output never shows a truncated or stretched pulse. When the generator is idle (period zero), a write starts the waveform at the very next clock edge.

Top module: `pwm_bus_gen`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears the stored word and the phase counter. After that edge `pwm_out` is 0 and `bus_rdata` is 0.
- R2: A write (`bus_wr` high at an edge) stores `bus_wdata` as one 32-bit word. A read (`bus_rd` high at an edge) presents the stored word on `bus_rdata` after that same edge, so there is one cycle of read latency. `bus_rdata` keeps its value while no read is issued.
- R3: Reads have no side effect on the waveform. A read and a write in the same cycle return the word that was stored before that write.
- R4: With period P = word[15:0] > 0 and high time H = word[31:16] < P, the output repeats every P cycles. It is high for the first H cycles of each period and low for the other P-H. With P = 0x000F and H = 0x0007, this gives 7 high cycles and 8 low cycles.
- R5: The output is held low when the active period is 0. It is also held low when the active high time is 0.
- R6: When H >= P > 0, the output is high in every cycle.
- R7: While running, a written word becomes active at the first period wrap after the write. A write at the edge where the counter wraps is adopted at that same wrap. The active period and high time never change in the middle of a period.
- R8: While idle (active period 0), a write takes effect at its own edge. The first period begins in the cycle after that edge, so the output is high in that cycle when H > 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write word: [15:0] period, [31:16] high time |
| bus_rdata | output | 32 | Read word, valid one cycle after the read |
| pwm_out | output | 1 | Modulated output |

## Verification
The case that needs most care is a write that lands on the exact edge where the phase counter wraps. At that moment the new word must be taken straight from the bus, not from the stored copy, which only updates at the same edge. The bench provokes this by watching its own model for the last cycle of a period and issuing the write there. It then compares every following output cycle against the model, which applies the new word from the next cycle on. The bench also provokes a read and a write in the same cycle, and judges it by expecting the word stored before that write.

// File: rtl/pwm_pkg.sv
// Package: shared defaults and helpers for the bus-mapped PWM.
// Assumes the configuration word is two equal halves: period low, high time high.
package pwm_pkg;
    localparam int DEF_HALF_W = 16;

    // Low half of a configuration word holds the period.
    function automatic logic [DEF_HALF_W-1:0] word_period(input logic [2*DEF_HALF_W-1:0] w);
        return w[DEF_HALF_W-1:0];
    endfunction

    // High half of a configuration word holds the high time.
    function automatic logic [DEF_HALF_W-1:0] word_high(input logic [2*DEF_HALF_W-1:0] w);
        return w[2*DEF_HALF_W-1:DEF_HALF_W];
    endfunction
endpackage

// File: rtl/pwm_cfg_port.sv
// Module: slave-side storage of the configuration word and read path.
// Assumes single-cycle strobes; read data registered, fixed latency one.
module pwm_cfg_port #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [WORD_W-1:0] cfg_word
);
    // Stored word: replaced as a whole by each write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_word <= '0;
        else if (bus_wr)
            cfg_word <= bus_wdata;
    end

    // Read register: captures the pre-write word on each read, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= cfg_word;
    end
endmodule

// File: rtl/pwm_period_engine.sv
// Module: phase counter and active configuration.
// Adopts a new period/high pair only at a period wrap, or at once when idle.
// Assumes a write in the wrap cycle is forwarded from the bus.
module pwm_period_engine #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] cfg_word,
    output logic [HALF_W-1:0] run_per,
    output logic [HALF_W-1:0] run_hi,
    output logic [HALF_W-1:0] ph_cnt
);
    logic [WORD_W-1:0] src_word;
    logic              idle;
    logic              at_wrap;
    logic              adopt;

    // Source of the next configuration: bus word wins over stored copy.
    always_comb begin
        src_word = bus_wr ? bus_wdata : cfg_word;
        idle     = (run_per == '0);
        at_wrap  = (ph_cnt == run_per - 1'b1);
        adopt    = idle || at_wrap;
    end

    // Counter and active pair: reload at wrap or idle, else step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_per <= '0;
            run_hi  <= '0;
            ph_cnt  <= '0;
        end else if (adopt) begin
            run_per <= src_word[HALF_W-1:0];
            run_hi  <= src_word[WORD_W-1:HALF_W];
            ph_cnt  <= '0;
        end else begin
            ph_cnt  <= ph_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_level_cmp.sv
// Module: output level from phase and active pair.
// Assumes counter below period; high while phase below high time.
module pwm_level_cmp #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0] run_per,
    input  logic [HALF_W-1:0] run_hi,
    input  logic [HALF_W-1:0] ph_cnt,
    output logic              pwm_out
);
    // Level decision: idle forces low, otherwise compare phase to high time.
    always_comb begin
        pwm_out = (run_per != '0) && (ph_cnt < run_hi);
    end
endmodule

// File: rtl/pwm_bus_gen.sv
// Module: top of the bus-mapped PWM, joins storage, engine and comparator.
// Assumes one configuration word split in equal period/high halves.
module pwm_bus_gen #(
    parameter int HALF_W = pwm_pkg::DEF_HALF_W,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              pwm_out
);
    logic [WORD_W-1:0] cfg_word;
    logic [HALF_W-1:0] run_per;
    logic [HALF_W-1:0] run_hi;
    logic [HALF_W-1:0] ph_cnt;

    pwm_cfg_port #(.WORD_W(WORD_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cfg_word (cfg_word)
    );

    pwm_period_engine #(.HALF_W(HALF_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .cfg_word (cfg_word),
        .run_per  (run_per),
        .run_hi   (run_hi),
        .ph_cnt   (ph_cnt)
    );

    pwm_level_cmp #(.HALF_W(HALF_W)) u_cmp (
        .run_per(run_per),
        .run_hi (run_hi),
        .ph_cnt (ph_cnt),
        .pwm_out(pwm_out)
    );
endmodule

// File: rtl/pwm_bus_gen_chk.sv
// Module: property checker bound to the PWM top.
// Assumes visibility of the active pair and phase counter through bind.
module pwm_bus_gen_chk #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              pwm_out,
    input logic [HALF_W-1:0] run_per,
    input logic [HALF_W-1:0] run_hi,
    input logic [HALF_W-1:0] ph_cnt
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!pwm_out && bus_rdata == '0));

    assert_read_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd) ##1 (bus_rd && !bus_wr) |=> bus_rdata == $past(bus_wdata, 2));

    assert_phase_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_per != '0) |-> (ph_cnt < run_per));

    assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_per == '0) |-> !pwm_out);

    assert_no_mid_period_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_per != '0 && ph_cnt != run_per - 1'b1) |=> ($stable(run_per) && $stable(run_hi)));

    assert_idle_write_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_per == '0 && bus_wr) |=> (run_per == $past(bus_wdata[HALF_W-1:0]) && ph_cnt == '0));
endmodule

bind pwm_bus_gen pwm_bus_gen_chk #(.HALF_W(HALF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pwm_out  (pwm_out),
    .run_per  (run_per),
    .run_hi   (run_hi),
    .ph_cnt   (ph_cnt)
);

// File: tb/sim_pwm_bus_gen.sv
// Bench: scoreboard for pwm_bus_gen. A model fed by the driven strobes pushes
// expected levels and read words into queues; a monitor pops and compares them.
module sim_pwm_bus_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "R1";
    bit done = 1'b0;

    // Expected-item queues.
    logic  q_lvl[$];
    string q_lvl_tag[$];
    logic [31:0] q_rd[$];
    string q_rd_tag[$];

    // Model state derived from the requirements.
    logic [31:0] m_word = '0;
    logic [15:0] m_per = '0;
    logic [15:0] m_hi = '0;
    logic [15:0] m_cnt = '0;

    always #5 clk = ~clk;

    pwm_bus_gen u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pwm_out  (pwm_out)
    );

    // Model: advance on each edge and push expected results for after it.
    always @(posedge clk) begin
        logic [31:0] src;
        logic [31:0] old_word;
        old_word = m_word;
        if (!rst_n) begin
            m_word = '0; m_per = '0; m_hi = '0; m_cnt = '0;
            q_rd_tag.push_back("R1");
            q_rd.push_back(32'h0);
        end else begin
            src = bus_wr ? bus_wdata : m_word;
            if (m_per == 16'd0 || m_cnt == m_per - 16'd1) begin
                m_per = src[15:0]; m_hi = src[31:16]; m_cnt = '0;
            end else begin
                m_cnt = m_cnt + 16'd1;
            end
            if (bus_wr) m_word = bus_wdata;
            if (bus_rd) begin
                q_rd.push_back(old_word);
                q_rd_tag.push_back(cur_tag);
            end
        end
        q_lvl.push_back((m_per != 16'd0) && (m_cnt < m_hi));
        q_lvl_tag.push_back(!rst_n ? "R1" : cur_tag);
    end

    // Monitor: compare away from the active edge.
    always @(negedge clk) begin
        while (q_lvl.size() > 0) begin
            logic  e;
            string t;
            e = q_lvl.pop_front();
            t = q_lvl_tag.pop_front();
            n_cmp++;
            if (pwm_out !== e) begin
                n_bad++;
                $display("FAIL %s pwm_out actual=%b expected=%b at %0t", t, pwm_out, e, $time);
            end
        end
        while (q_rd.size() > 0) begin
            logic [31:0] e;
            string t;
            e = q_rd.pop_front();
            t = q_rd_tag.pop_front();
            n_cmp++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s bus_rdata actual=%h expected=%h at %0t", t, bus_rdata, e, $time);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [31:0] w, input logic with_rd);
        @(negedge clk);
        bus_wr = 1'b1; bus_wdata = w; bus_rd = with_rd;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic bus_read();
        @(negedge clk);
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Watchdog: a hang is a failed check.
    initial begin
        #200000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        cur_tag = "R1";
        idle(3);
        rst_n = 1'b1;
        bus_read();
        idle(2);

        // R8: write from idle starts at once; R4 pulse train 7 of 15.
        cur_tag = "R8";
        bus_write(32'h0007_000F, 1'b0);
        cur_tag = "R4";
        idle(40);

        // R2: readback of the stored word.
        cur_tag = "R2";
        bus_read();

        // R3: continuous reads leave the waveform alone.
        cur_tag = "R3";
        @(negedge clk); bus_rd = 1'b1;
        idle(12);
        bus_rd = 1'b0;
        // R3: read with write in the same cycle returns the earlier word.
        bus_write(32'h0003_0008, 1'b1);

        // R7: mid-period write applied at next wrap.
        cur_tag = "R7";
        idle(3);
        bus_write(32'h0002_0005, 1'b0);
        idle(20);
        // R7: write landing on the wrap edge itself.
        while (!(m_per != 16'd0 && m_cnt == m_per - 16'd1)) @(negedge clk);
        bus_wr = 1'b1; bus_wdata = 32'h0004_0006;
        @(negedge clk);
        bus_wr = 1'b0;
        idle(20);
        cur_tag = "R2";
        bus_read();

        // R6: high time equal to and above period.
        cur_tag = "R6";
        bus_write(32'h0009_0009, 1'b0);
        idle(25);
        bus_write(32'h0020_0004, 1'b0);
        idle(15);

        // R5: zero high time, then zero period.
        cur_tag = "R5";
        bus_write(32'h0000_000A, 1'b0);
        idle(25);
        bus_write(32'h0005_0000, 1'b0);
        idle(15);

        // R8: restart from idle with period 1 and period 3.
        cur_tag = "R8";
        bus_write(32'h0001_0001, 1'b0);
        idle(5);
        bus_write(32'h0001_0003, 1'b0);
        idle(12);

        // R1: reset while running.
        cur_tag = "R1";
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        bus_read();
        idle(3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule